// File: doc/BRIEF.md
# Tagged Multi-Line Receive Silo

This block is the shared receive store of a sixteen-line asynchronous multiplexer. Each line receiver hands over a finished character with a one-cycle strobe, together with its parity-error and framing-error flags. The block holds each character in a per-line capture register and moves one of them per cycle into a 64-entry first-in first-out store. The lowest-numbered waiting line goes first. Each stored entry carries the character, the number of the line it came from, and its error flags.

Software reaches the block through a small register port with a select field and read and write strobes. Reading the receive word returns the oldest entry and removes it. Bit 15 of that word shows that an entry was present, so software drains the store by reading until the word has bit 15 clear. If the store is full when a character reaches it, the character is discarded, and the next character that is stored carries an overrun mark.

Two interrupt outputs are provided. The receive interrupt is raised while the store holds data and its enable is set. The storage interrupt is raised when the fill count reaches a programmable alarm level and its own enable is set.

Top module: `mux_rx_silo`

## Requirements
- R1: Reading the receive word (select 1) while the store holds data returns bit 15 = 1. Reading it while the store is empty returns 16'h0000.
- R2: In a valid receive word, bits 7:0 hold the character and bits 11:8 hold the number of the line that delivered it (0 to 15).
- R3: Bit 12 of the receive word is the parity-error flag and bit 13 is the framing-error flag that arrived with that character.
- R4: Entries are returned in the order they were stored. The store holds up to 64 entries.
- R5: A character that reaches a full store is discarded. The next character that is stored has bit 14 (overrun) set, and entries stored after it have bit 14 clear.
- R6: Each read of the receive word removes exactly one entry. A read of an empty store removes nothing. Reads of any other select never remove an entry.
- R7: Control word (select 0) bit 7 reads 1 while the store is non-empty. Bit 6 is the read/write receive-interrupt enable. Output `rx_irq` equals bit 7 AND bit 6.
- R8: The alarm-level word (select 2) is 7 bits wide, is readable and writable in bits 6:0, and resets to 16. Control bit 14 reads 1 when the level is non-zero and the fill count is greater than or equal to the level. Control bit 12 is the read/write storage-interrupt enable. Output `store_irq` equals bit 14 AND bit 12.
- R9: When several lines present characters in the same cycle, they are stored one per cycle in ascending line order.
- R10: A character strobed before rising edge k is readable after edge k+1.
- R11: Select 3 reads as 16'h0000. Writes to selects 1 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_strobe | input | NUM_LINES | One-cycle character-ready strobe, one bit per line |
| line_data | input | NUM_LINES*8 | Character of each line; line n uses bits 8n+7:8n |
| line_perr | input | NUM_LINES | Parity-error flag of each line, valid with its strobe |
| line_ferr | input | NUM_LINES | Framing-error flag of each line, valid with its strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 receive word, 2 alarm level |
| reg_rd | input | 1 | Read strobe; on select 1 it removes the head entry at the clock edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the current select (combinational) |
| rx_irq | output | 1 | Receive interrupt |
| store_irq | output | 1 | Storage (alarm) interrupt |

## Verification
The checker assertions are evaluated on every cycle. They check the following:
- the fill count never passes the depth and never rises by more than one per cycle;
- a receive read removes exactly one entry, and an empty read returns zero;
- bit 15 of the receive word matches the occupancy of the store;
- both interrupt outputs agree with their enables, the fill count and the alarm level.

Some properties can only be shown by the bench scenarios:
- entries come back in the order they were stored, with the right data, line tags and error flags;
- the lowest line wins when several strobe together;
- the overrun mark lands on exactly one entry after the drops;
- the storage interrupt switches at the right fill count as the store is swept from empty to full.

// File: rtl/mrs_pkg.sv
// Shared types and register layout for the tagged receive silo.
// Assumes at most 16 lines and 8-bit characters, which the 16-bit read word fixes.
package mrs_pkg;
    localparam int CHAR_W     = 8;
    localparam int LINE_FLD_W = 4;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_RXW  = 2'd1;
    localparam logic [1:0] SEL_LVL  = 2'd2;

    localparam int CB_RIE  = 6;
    localparam int CB_RI   = 7;
    localparam int CB_SIE  = 12;
    localparam int CB_SI   = 14;

    // One stored entry: the order of the fields is the read-word bit order 14:0
    typedef struct packed {
        logic                  ovr;
        logic                  ferr;
        logic                  perr;
        logic [LINE_FLD_W-1:0] line;
        logic [CHAR_W-1:0]     ch;
    } silo_entry_t;
endpackage

// File: rtl/mrs_line_capture.sv
// Per-line capture registers and a fixed-priority picker.
// Each line keeps its last strobed character until it is granted.
// The lowest-numbered pending line is granted once per cycle.
// Assumes a line does not strobe again before its previous character is granted.
// If it does, the newer character replaces the older one.
module mrs_line_capture
    import mrs_pkg::*;
#(
    parameter int NUM_LINES = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        strobe,
    input  logic [NUM_LINES*CHAR_W-1:0] data,
    input  logic [NUM_LINES-1:0]        perr,
    input  logic [NUM_LINES-1:0]        ferr,
    input  logic                        accept,
    output logic                        grant_vld,
    output silo_entry_t                 grant_entry
);
    logic [NUM_LINES-1:0] pend;
    logic [CHAR_W-1:0]    ch_arr [NUM_LINES];
    logic [NUM_LINES-1:0] pe_arr;
    logic [NUM_LINES-1:0] fe_arr;
    logic [LINE_FLD_W-1:0] gidx;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic              pend_q;
        logic [CHAR_W-1:0] ch_q;
        logic              pe_q;
        logic              fe_q;

        // Hold a line's character from its strobe until the picker takes it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
                ch_q   <= '0;
                pe_q   <= 1'b0;
                fe_q   <= 1'b0;
            end else if (strobe[g]) begin
                pend_q <= 1'b1;
                ch_q   <= data[g*CHAR_W +: CHAR_W];
                pe_q   <= perr[g];
                fe_q   <= ferr[g];
            end else if (accept && grant_vld && gidx == LINE_FLD_W'(g)) begin
                pend_q <= 1'b0;
            end
        end

        assign pend[g]   = pend_q;
        assign ch_arr[g] = ch_q;
        assign pe_arr[g] = pe_q;
        assign fe_arr[g] = fe_q;
    end

    // Pick the lowest-numbered pending line
    always_comb begin
        gidx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (pend[i]) gidx = LINE_FLD_W'(i);
        end
    end

    assign grant_vld = |pend;

    // Form the entry of the granted line; the overrun mark is added by the top
    always_comb begin
        grant_entry      = '0;
        grant_entry.line = gidx;
        grant_entry.ch   = ch_arr[gidx];
        grant_entry.perr = pe_arr[gidx];
        grant_entry.ferr = fe_arr[gidx];
    end
endmodule

// File: rtl/mrs_fifo.sv
// Storage array for silo entries with a fill counter.
// The caller must not push when full or pop when empty.
// DEPTH must be a power of two.
module mrs_fifo
    import mrs_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  silo_entry_t      wentry,
    input  logic             pop,
    output silo_entry_t      head,
    output logic [CNT_W-1:0] fill
);
    silo_entry_t      mem [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;

    // Write the pushed entry into the array
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wentry;
    end

    // Advance the pointers and track the fill count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (push) wptr <= wptr + PTR_W'(1);
            if (pop)  rptr <= rptr + PTR_W'(1);
            case ({push, pop})
                2'b10:   fill <= fill + CNT_W'(1);
                2'b01:   fill <= fill - CNT_W'(1);
                default: fill <= fill;
            endcase
        end
    end

    assign head = mem[rptr];
endmodule

// File: rtl/mux_rx_silo.sv
// Top of the tagged receive silo.
// Combines the line capture stage and the entry store with the control,
// receive-word and alarm-level registers.
// Assumes NUM_LINES <= 16 and a power-of-two DEPTH.
// Read data is combinational from reg_sel. A receive-word read removes the head entry at the edge.
module mux_rx_silo
    import mrs_pkg::*;
#(
    parameter int NUM_LINES   = 16,
    parameter int DEPTH       = 64,
    parameter int ALARM_RESET = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        line_strobe,
    input  logic [NUM_LINES*CHAR_W-1:0] line_data,
    input  logic [NUM_LINES-1:0]        line_perr,
    input  logic [NUM_LINES-1:0]        line_ferr,
    input  logic [1:0]                  reg_sel,
    input  logic                        reg_rd,
    input  logic                        reg_wr,
    input  logic [15:0]                 reg_wdata,
    output logic [15:0]                 reg_rdata,
    output logic                        rx_irq,
    output logic                        store_irq
);
    logic             grant_vld;
    silo_entry_t      grant_entry;
    silo_entry_t      store_entry;
    silo_entry_t      head;
    logic [CNT_W-1:0] fill;
    logic             full;
    logic             nonempty;
    logic             push;
    logic             drop;
    logic             pop;
    logic             ovr_pend;
    logic             rie;
    logic             sie;
    logic [CNT_W-1:0] level;
    logic             alarm;

    mrs_line_capture #(.NUM_LINES(NUM_LINES)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe      (line_strobe),
        .data        (line_data),
        .perr        (line_perr),
        .ferr        (line_ferr),
        .accept      (1'b1),
        .grant_vld   (grant_vld),
        .grant_entry (grant_entry)
    );

    assign full     = (fill == CNT_W'(DEPTH));
    assign nonempty = (fill != '0);
    assign push     = grant_vld && !full;
    assign drop     = grant_vld && full;
    assign pop      = reg_rd && (reg_sel == SEL_RXW) && nonempty;

    // Mark the entry with any overrun left by earlier drops
    always_comb begin
        store_entry     = grant_entry;
        store_entry.ovr = ovr_pend;
    end

    mrs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .wentry (store_entry),
        .pop    (pop),
        .head   (head),
        .fill   (fill)
    );

    // Remember a drop until the next entry is stored
    always_ff @(posedge clk) begin
        if (!rst_n)    ovr_pend <= 1'b0;
        else if (drop) ovr_pend <= 1'b1;
        else if (push) ovr_pend <= 1'b0;
    end

    // Software-writable enables and alarm level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rie   <= 1'b0;
            sie   <= 1'b0;
            level <= CNT_W'(ALARM_RESET);
        end else if (reg_wr) begin
            if (reg_sel == SEL_CTRL) begin
                rie <= reg_wdata[CB_RIE];
                sie <= reg_wdata[CB_SIE];
            end else if (reg_sel == SEL_LVL) begin
                level <= reg_wdata[CNT_W-1:0];
            end
        end
    end

    assign alarm = (level != '0) && (fill >= level);

    // Read data mux for the selected register
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTRL: begin
                reg_rdata[CB_RIE] = rie;
                reg_rdata[CB_RI]  = nonempty;
                reg_rdata[CB_SIE] = sie;
                reg_rdata[CB_SI]  = alarm;
            end
            SEL_RXW:  reg_rdata = nonempty ? {1'b1, head} : 16'h0000;
            SEL_LVL:  reg_rdata = 16'(level);
            default:  reg_rdata = '0;
        endcase
    end

    assign rx_irq    = rie && nonempty;
    assign store_irq = sie && alarm;
endmodule

// File: rtl/mrs_checker.sv
// Cycle-level properties of the receive silo, bound to the top module.
// Observes the ports plus the fill count, enables, alarm level and grant.
module mrs_checker #(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_sel,
    input logic             reg_rd,
    input logic [15:0]      reg_rdata,
    input logic             rx_irq,
    input logic             store_irq,
    input logic [CNT_W-1:0] fill,
    input logic             rie,
    input logic             sie,
    input logic [CNT_W-1:0] level,
    input logic             grant_vld
);
    // R4: the fill count never passes the depth
    a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    // R9: at most one entry enters per cycle
    a_r9_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (fill <= $past(fill) + CNT_W'(1)));

    // R6: a receive read with no arrival lowers the count by exactly one
    a_r6_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == 2'd1 && fill != '0 && !grant_vld)
            |=> (fill == $past(fill) - CNT_W'(1)));

    // R6: a read of any other register leaves the count alone when nothing arrives
    a_r6_other_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel != 2'd1 && !grant_vld) |=> $stable(fill));

    // R1: an empty receive read yields zero
    a_r1_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd1 && fill == '0) |-> (reg_rdata == 16'h0000));

    // R1: the valid bit follows occupancy
    a_r1_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd1 && fill != '0) |-> reg_rdata[15]);

    // R7: receive interrupt agrees with enable and occupancy
    a_r7_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq == (rie && fill != '0));

    // R8: storage interrupt only with enable, non-zero level and fill at level
    a_r8_store_irq: assert property (@(posedge clk) disable iff (!rst_n)
        store_irq |-> (sie && level != '0 && fill >= level));
endmodule

bind mux_rx_silo mrs_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .rx_irq    (rx_irq),
    .store_irq (store_irq),
    .fill      (fill),
    .rie       (rie),
    .sie       (sie),
    .level     (level),
    .grant_vld (grant_vld)
);

// File: tb/sim_mux_rx_silo.sv
// Self-checking bench for the receive silo: line sweep, priority, fill sweep and overrun.
module sim_mux_rx_silo;
    localparam int NL = 16;
    localparam int DP = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL-1:0]   line_strobe = '0;
    logic [NL*8-1:0] line_data = '0;
    logic [NL-1:0]   line_perr = '0;
    logic [NL-1:0]   line_ferr = '0;
    logic [1:0]      reg_sel = 2'd0;
    logic            reg_rd = 1'b0;
    logic            reg_wr = 1'b0;
    logic [15:0]     reg_wdata = '0;
    logic [15:0]     reg_rdata;
    logic            rx_irq;
    logic            store_irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic [15:0] v;

    always #2.5 clk = ~clk;

    mux_rx_silo #(.NUM_LINES(NL), .DEPTH(DP), .ALARM_RESET(16)) u0 (
        .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .line_data(line_data),
        .line_perr(line_perr), .line_ferr(line_ferr), .reg_sel(reg_sel), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_irq(rx_irq), .store_irq(store_irq)
    );

    function automatic logic [15:0] word(bit ov, bit fe, bit pe, int ln, logic [7:0] ch);
        return {1'b1, ov, fe, pe, 4'(ln), ch};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [15:0] val);
        @(negedge clk);
        reg_sel = a;
        reg_rd  = 1'b1;
        #1 val  = reg_rdata;
        @(negedge clk);
        reg_rd  = 1'b0;
    endtask

    task automatic wr_reg(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        reg_sel   = a;
        reg_wr    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    // Strobe one line; returns after the capture edge and the store edge
    task automatic push_one(int ln, logic [7:0] ch, bit pe, bit fe);
        @(negedge clk);
        line_strobe[ln]       = 1'b1;
        line_data[ln*8 +: 8]  = ch;
        line_perr[ln]         = pe;
        line_ferr[ln]         = fe;
        @(negedge clk);
        line_strobe = '0;
        line_perr   = '0;
        line_ferr   = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        rd_reg(2'd1, v); check("R1 empty after reset", v, 16'h0000);
        rd_reg(2'd0, v); check("R7 control after reset", v, 16'h0000);
        rd_reg(2'd2, v); check("R8 level reset", v, 16'd16);
        check("R7 rx_irq reset", {15'd0, rx_irq}, 16'd0);

        // R2 R3: every line, flag patterns from line number
        for (int ln = 0; ln < NL; ln++) begin
            logic [7:0] ch = 8'(ln * 37 + 5);
            push_one(ln, ch, ln[0], ln[1]);
            rd_reg(2'd0, v); check("R7 RI set when data held", {15'd0, v[7]}, 16'd1);
            rd_reg(2'd1, v); check("R2 R3 tagged word", v, word(0, ln[1], ln[0], ln, ch));
            rd_reg(2'd1, v); check("R6 single pop then empty", v, 16'h0000);
        end

        // R11: unused select and writes to read-only selects
        wr_reg(2'd1, 16'hFFFF);
        wr_reg(2'd3, 16'hFFFF);
        rd_reg(2'd3, v); check("R11 select 3 reads zero", v, 16'h0000);
        rd_reg(2'd0, v); check("R11 control untouched", v, 16'h0000);

        // R7 and R10: enable, latency
        wr_reg(2'd0, 16'h0040);
        check("R7 rx_irq off while empty", {15'd0, rx_irq}, 16'd0);
        @(negedge clk);
        line_strobe[9] = 1'b1; line_data[9*8 +: 8] = 8'h3C;
        @(negedge clk);
        line_strobe = '0;
        check("R10 not yet stored after capture edge", {15'd0, rx_irq}, 16'd0);
        @(negedge clk);
        check("R10 stored after next edge", {15'd0, rx_irq}, 16'd1);
        rd_reg(2'd0, v); check("R7 control with RIE and RI", v, 16'h00C0);
        rd_reg(2'd2, v); check("R6 level read does not pop", {15'd0, rx_irq}, 16'd1);
        rd_reg(2'd1, v); check("R10 word", v, word(0, 0, 0, 9, 8'h3C));
        check("R7 rx_irq off after drain", {15'd0, rx_irq}, 16'd0);

        // R9: all lines strobe together, level 3 shows one entry per cycle
        wr_reg(2'd2, 16'd3);
        wr_reg(2'd0, 16'h1000);
        @(negedge clk);
        for (int ln = 0; ln < NL; ln++) line_data[ln*8 +: 8] = 8'(8'hA0 + ln);
        line_strobe = '1;
        @(negedge clk);
        line_strobe = '0;
        @(negedge clk);
        @(negedge clk);
        check("R9 two entries below level 3", {15'd0, store_irq}, 16'd0);
        @(negedge clk);
        check("R9 third entry reaches level", {15'd0, store_irq}, 16'd1);
        repeat (20) @(negedge clk);
        for (int ln = 0; ln < NL; ln++) begin
            rd_reg(2'd1, v); check("R9 ascending line order", v, word(0, 0, 0, ln, 8'(8'hA0 + ln)));
        end

        // R4 R8: fill sweep to full with level 16
        wr_reg(2'd2, 16'd16);
        for (int n = 1; n <= DP; n++) begin
            push_one(n % NL, 8'(n), 0, 0);
            check("R8 store_irq at fill", {15'd0, store_irq}, {15'd0, n >= 16});
        end
        rd_reg(2'd0, v); check("R8 control SI SIE RI when full", v, 16'h5080);

        // R5: three characters reach a full store
        push_one(1, 8'h11, 0, 0);
        push_one(2, 8'h22, 1, 0);
        push_one(3, 8'h33, 0, 1);
        for (int n = 1; n <= DP; n++) begin
            rd_reg(2'd1, v); check("R4 R5 ordered drain, no drop visible", v, word(0, 0, 0, n % NL, 8'(n)));
        end
        rd_reg(2'd1, v); check("R1 empty after drain", v, 16'h0000);
        push_one(7, 8'h5A, 0, 0);
        push_one(8, 8'h5B, 0, 0);
        rd_reg(2'd1, v); check("R5 overrun marked once", v, word(1, 0, 0, 7, 8'h5A));
        rd_reg(2'd1, v); check("R5 overrun cleared", v, word(0, 0, 0, 8, 8'h5B));

        // R8: level zero disables the alarm
        wr_reg(2'd2, 16'd0);
        push_one(4, 8'h44, 0, 0);
        check("R8 level zero no alarm", {15'd0, store_irq}, 16'd0);
        rd_reg(2'd1, v); check("R6 last entry", v, word(0, 0, 0, 4, 8'h44));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule